// File: doc/BRIEF.md
# Software-Generated Interrupt Target Decoder

This block takes a 64-bit request word that software writes to raise a software-generated interrupt and works out which processors must receive it. Each of the `NUM_TARGETS` processors is described at build time by a 32-bit affinity value made of four 8-bit levels. The decoder compares the request against every affinity in parallel. In the same cycle it raises one send strobe for each selected processor, and it forwards the 4-bit interrupt number, the group code and the non-secure flag alongside the strobes.

Two routing modes exist. In list mode, a processor is selected when all of these hold:
- its three upper affinity levels equal the ones named in the word;
- its lowest level falls in the 16-wide window chosen by a range selector;
- the list bit for its offset inside that window is set.

In broadcast mode, every processor except the requester is selected, and the list and affinity fields are disregarded. What a receiving processor does after the strobe is outside this block.

Top module: `sgiTargetDecoder`

## Requirements
- R1: While `reqValid` is low, `sendStrobe` is all zeros, whatever the word holds.
- R2: While `reqValid` is high, `sendIntId` equals word bits 27:24, `sendGroup` equals `reqGroup` and `sendNonSecure` equals `reqNonSecure`, all in the same cycle as the request.
- R3: In list mode (word bit 40 clear), a target is selected only if its affinity bits 31:8 equal {word[55:48], word[39:32], word[23:16]}, taken as levels 3, 2 and 1.
- R4: In list mode, a target whose lowest affinity level is a0 is selected only if a0[7:4] equals the range selector in word bits 47:44 and the list bit word[a0[3:0]] is set. The list occupies word bits 15:0.
- R5: In broadcast mode (word bit 40 set), every target whose index differs from `requesterIdx` is strobed, and the requester is not.
- R6: In broadcast mode with `requesterIdx` equal to or above `NUM_TARGETS`, every target is strobed.
- R7: The following have no effect on the strobes: word bits 63:56, 43:41 and 31:28; list bits that match no target's offset; and, in broadcast mode, the list, range and affinity fields.
- R8: The strobes are combinational. They follow the request in the same cycle and hold no state between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqValid | input | 1 | Request word is valid this cycle |
| reqWord | input | 64 | Request word |
| reqGroup | input | 2 | Group code, forwarded unchanged |
| reqNonSecure | input | 1 | Non-secure qualifier, forwarded unchanged |
| requesterIdx | input | IDX_W | Index of the requesting processor |
| sendStrobe | output | NUM_TARGETS | One send strobe per target |
| sendIntId | output | 4 | Interrupt number sent with the strobes |
| sendGroup | output | 2 | Group code sent with the strobes |
| sendNonSecure | output | 1 | Non-secure flag sent with the strobes |

## Verification
The checker evaluates some properties on every input change:
- an idle request produces no strobes;
- the fields are forwarded unchanged;
- a broadcast never strobes the requester and strobes exactly the expected number of targets;
- a list-mode request never strobes more targets than it has list bits set.

Whether the correct target is chosen depends on the affinity table, so only the bench scenarios can show it. These scenarios cover:
- a match on each upper affinity level;
- windows other than the first;
- list bits that match no target;
- garbage in the ignored fields;
- a requester index out of range.

// File: rtl/sgiPkg.sv
package sgiPkg;
  // Decoded command from control to the per-target match datapath.
  typedef struct packed {
    logic        fire;        // request present
    logic        toAll;       // broadcast except requester
    logic [3:0]  rangeSel;    // selects 16-wide window of lowest level
    logic [23:0] upperAff;    // {level3, level2, level1}
    logic [15:0] targetList;  // per-offset select bits
  } sgiCmd_t;
endpackage

// File: rtl/sgiDecodeCtrl.sv
module sgiDecodeCtrl
  import sgiPkg::*;
(
  input  logic        reqValid,
  input  logic [63:0] reqWord,
  output sgiCmd_t     cmd,
  output logic [3:0]  intId
);
  // Fields of the word that carry no meaning for routing.
  logic unusedBits;
  assign unusedBits = ^{reqWord[63:56], reqWord[43:41], reqWord[31:28]};

  always_comb begin
    cmd.fire       = reqValid;
    cmd.toAll      = reqWord[40];
    cmd.rangeSel   = reqWord[47:44];
    cmd.upperAff   = {reqWord[55:48], reqWord[39:32], reqWord[23:16]};
    cmd.targetList = reqWord[15:0];
    intId          = reqWord[27:24];
  end
endmodule

// File: rtl/sgiTargetMatch.sv
module sgiTargetMatch
  import sgiPkg::*;
#(
  parameter int NUM_TARGETS = 8,
  parameter logic [31:0] TARGET_AFF [NUM_TARGETS] = '{default: 32'h0},
  parameter int IDX_W = $clog2(NUM_TARGETS + 1)
) (
  input  sgiCmd_t                 cmd,
  input  logic [IDX_W-1:0]        requesterIdx,
  output logic [NUM_TARGETS-1:0]  strobe
);
  for (genvar g = 0; g < NUM_TARGETS; g++) begin : genTarget
    localparam logic [31:0] AFF = TARGET_AFF[g];
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic upperHit, windowHit, listHit, isSelf;
    always_comb begin
      upperHit  = (AFF[31:8] == cmd.upperAff);
      windowHit = (AFF[7:4] == cmd.rangeSel);
      listHit   = cmd.targetList[AFF[3:0]];
      isSelf    = (requesterIdx == MY_IDX);
      strobe[g] = cmd.fire & (cmd.toAll ? !isSelf
                                        : (upperHit & windowHit & listHit));
    end
  end
endmodule

// File: rtl/sgiTargetDecoder.sv
module sgiTargetDecoder
  import sgiPkg::*;
#(
  parameter int NUM_TARGETS = 8,
  parameter logic [31:0] TARGET_AFF [NUM_TARGETS] = '{
    32'h0000_0000, 32'h0000_0001, 32'h0000_0011, 32'h0000_0102,
    32'h0001_0003, 32'h0100_0005, 32'h0000_000F, 32'h0000_0020},
  localparam int IDX_W = $clog2(NUM_TARGETS + 1)
) (
  input  logic                    reqValid,
  input  logic [63:0]             reqWord,
  input  logic [1:0]              reqGroup,
  input  logic                    reqNonSecure,
  input  logic [IDX_W-1:0]        requesterIdx,
  output logic [NUM_TARGETS-1:0]  sendStrobe,
  output logic [3:0]              sendIntId,
  output logic [1:0]              sendGroup,
  output logic                    sendNonSecure
);
  sgiCmd_t cmd;

  sgiDecodeCtrl uCtrl (
    .reqValid (reqValid),
    .reqWord  (reqWord),
    .cmd      (cmd),
    .intId    (sendIntId)
  );

  sgiTargetMatch #(
    .NUM_TARGETS (NUM_TARGETS),
    .TARGET_AFF  (TARGET_AFF),
    .IDX_W       (IDX_W)
  ) uMatch (
    .cmd          (cmd),
    .requesterIdx (requesterIdx),
    .strobe       (sendStrobe)
  );

  assign sendGroup     = reqGroup;
  assign sendNonSecure = reqNonSecure;
endmodule

// File: rtl/sgiTargetDecoder_chk.sv
module sgiTargetDecoder_chk #(
  parameter int NUM_TARGETS = 8,
  parameter int IDX_W = 4
) (
  input logic                   reqValid,
  input logic [63:0]            reqWord,
  input logic [1:0]             reqGroup,
  input logic                   reqNonSecure,
  input logic [IDX_W-1:0]       requesterIdx,
  input logic [NUM_TARGETS-1:0] sendStrobe,
  input logic [3:0]             sendIntId,
  input logic [1:0]             sendGroup,
  input logic                   sendNonSecure
);
  logic known;
  always_comb begin
    known = !$isunknown({reqValid, reqWord, reqGroup, reqNonSecure, requesterIdx});
    if (known) begin
      AST_IDLE_QUIET: assert (reqValid || sendStrobe == '0) else $error("idle strobe"); // R1
      AST_FIELDS_FORWARDED: assert (!reqValid || (sendIntId == reqWord[27:24] &&
        sendGroup == reqGroup && sendNonSecure == reqNonSecure)) else $error("fields"); // R2
      AST_BCAST_SKIPS_SELF: assert (!(reqValid && reqWord[40] && int'(requesterIdx) < NUM_TARGETS)
        || !sendStrobe[requesterIdx]) else $error("self strobed"); // R5
      AST_BCAST_COUNT: assert (!(reqValid && reqWord[40]) ||
        $countones(sendStrobe) == ((int'(requesterIdx) < NUM_TARGETS) ? NUM_TARGETS - 1 : NUM_TARGETS))
        else $error("broadcast count"); // R6
      AST_LIST_BOUND: assert (!(reqValid && !reqWord[40]) ||
        $countones(sendStrobe) <= $countones(reqWord[15:0])) else $error("list bound"); // R4
    end
  end
endmodule

bind sgiTargetDecoder sgiTargetDecoder_chk #(
  .NUM_TARGETS (NUM_TARGETS),
  .IDX_W       (IDX_W)
) uChk (.*);

// File: tb/tb_sgiTargetDecoder.sv
module tb_sgiTargetDecoder;
  localparam int N = 8;
  localparam int IW = $clog2(N + 1);
  localparam logic [31:0] AFF [N] = '{
    32'h0000_0000, 32'h0000_0001, 32'h0000_0011, 32'h0000_0102,
    32'h0001_0003, 32'h0100_0005, 32'h0000_000F, 32'h0000_0020};

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic [63:0] reqWord = '0;
  logic [1:0] reqGroup = '0;
  logic reqNonSecure = 0;
  logic [IW-1:0] requesterIdx = '0;
  logic [N-1:0] sendStrobe;
  logic [3:0] sendIntId;
  logic [1:0] sendGroup;
  logic sendNonSecure;
  int checks = 0, fails = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  sgiTargetDecoder #(.NUM_TARGETS(N), .TARGET_AFF(AFF)) dut (.*);

  // Behavioural reference: scan targets with plain integers.
  function automatic logic [N-1:0] model(logic v, logic [63:0] w, int req);
    logic [N-1:0] r = '0;
    int rs, a0, off;
    if (!v) return r;
    rs = int'(w[47:44]);
    for (int i = 0; i < N; i++) begin
      if (w[40]) r[i] = (i != req);
      else begin
        a0 = int'(AFF[i][7:0]);
        off = a0 - rs * 16;
        r[i] = (AFF[i][31:24] == w[55:48]) && (AFF[i][23:16] == w[39:32]) &&
               (AFF[i][15:8] == w[23:16]) && off >= 0 && off < 16 && w[off];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] mk(logic [15:0] lst, logic [3:0] id, logic [7:0] a1,
                                     logic [7:0] a2, logic [7:0] a3, logic [3:0] rs, logic all);
    logic [63:0] w = '0;
    w[15:0] = lst; w[27:24] = id; w[23:16] = a1; w[39:32] = a2;
    w[55:48] = a3; w[47:44] = rs; w[40] = all;
    return w;
  endfunction

  // Reference comparison every cycle, away from the driving edge.
  always @(negedge clk) if (rstN) begin
    logic [N-1:0] e;
    e = model(reqValid, reqWord, int'(requesterIdx));
    checks++;
    if (sendStrobe !== e) begin
      fails++;
      $display("FAIL %s strobe actual=%b expected=%b", curReq, sendStrobe, e);
    end
    if (reqValid) begin
      checks++;
      if (sendIntId !== reqWord[27:24] || sendGroup !== reqGroup || sendNonSecure !== reqNonSecure) begin
        fails++;
        $display("FAIL R2 fields actual=%h/%h/%b expected=%h/%h/%b", sendIntId, sendGroup,
                 sendNonSecure, reqWord[27:24], reqGroup, reqNonSecure);
      end
    end
  end

  task automatic drive(string tag, logic v, logic [63:0] w, int req, logic [N-1:0] lit);
    @(posedge clk);
    curReq = tag; reqValid = v; reqWord = w; requesterIdx = IW'(req);
    reqGroup = reqGroup + 2'd1; reqNonSecure = ~reqNonSecure;
    @(negedge clk); #1;
    checks++;
    if (sendStrobe !== lit) begin
      fails++;
      $display("FAIL %s literal actual=%b expected=%b", tag, sendStrobe, lit);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1;
    drive("R1", 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 8'h00);            // R1 idle with busy word
    drive("R3", 1, mk(16'h0002, 4'h3, 0, 0, 0, 0, 0), 0, 8'h02);  // R3 level match
    drive("R4", 1, mk(16'h0002, 4'h5, 0, 0, 0, 1, 0), 0, 8'h04);  // R4 window 1
    drive("R4", 1, mk(16'h0001, 4'h6, 0, 0, 0, 2, 0), 0, 8'h80);  // R4 window 2
    drive("R3", 1, mk(16'h0004, 4'h7, 1, 0, 0, 0, 0), 0, 8'h08);  // R3 level1
    drive("R3", 1, mk(16'h0008, 4'h8, 0, 1, 0, 0, 0), 0, 8'h10);  // R3 level2
    drive("R3", 1, mk(16'h0020, 4'h9, 0, 0, 1, 0, 0), 0, 8'h20);  // R3 level3
    drive("R4", 1, mk(16'hFFFF, 4'hA, 0, 0, 0, 0, 0), 0, 8'h43);  // R4 full list
    drive("R5", 1, mk(16'h0000, 4'hB, 0, 0, 0, 0, 1), 2, 8'hFB);  // R5 broadcast
    drive("R6", 1, mk(16'h0000, 4'hC, 0, 0, 0, 0, 1), 8, 8'hFF);  // R6 out-of-range requester
    drive("R7", 1, mk(16'h0012, 4'hD, 0, 0, 0, 0, 0) | 64'hFF00_0E00_F000_0000, 0, 8'h02); // R7
    drive("R7", 1, mk(16'h0001, 4'hE, 7, 7, 7, 9, 1), 5, 8'hDF);  // R7 fields ignored in broadcast
    drive("R8", 0, mk(16'h0001, 4'h1, 0, 0, 0, 0, 0), 0, 8'h00);  // R8 no held state
    drive("R2", 1, mk(16'h8000, 4'hF, 0, 0, 0, 0, 0), 0, 8'h40);  // R2 forwarding
    for (int k = 0; k < 300; k++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      if (k % 3 != 0) begin w[55:48] = '0; w[39:32] = '0; w[23:16] = '0; w[47:46] = '0; end
      @(posedge clk);
      curReq = "R8";
      reqValid = ($urandom % 4) != 0; reqWord = w; requesterIdx = IW'($urandom % 10);
      reqGroup = 2'($urandom); reqNonSecure = 1'($urandom);
    end
    @(posedge clk); reqValid = 0;
    @(negedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule